// File: doc/BRIEF.md
# Sample Rate Ratio Tracking Loop

This block follows two sample clocks that arrive as single-cycle strobes in a fast system clock. One strobe marks the input sample rate and the other marks the output sample rate. A free-running counter advances on each input strobe. It serves as the write address of a sample buffer and as the ramp that the loop tracks.

Every output period yields one coarse measurement: the whole number of input strobes seen in that period. A first-order exponential filter averages these measurements into a ratio estimate with 20 fractional bits. Averaging many coarse counts gives a resolution far finer than a single clock cycle, with no fine timing hardware.

At each output strobe, a position accumulator advances by the estimated ratio. Its fractional part is the 20-bit phase that selects filter coefficients. Its integer part is the read start address of the sample buffer. A small correction term keeps the read address a fixed distance behind the write address. A lock flag reports when the estimate has settled.

Top module: `rate_tracker`

## Requirements
- R1: After reset, the outputs are as follows: `wr_addr` is 0, `rd_addr` is 2^AW − OFFSET (496 with defaults), `phase` is 0, `ratio` is 1.0 (1 << 20) and `locked` is 0.
- R2: Each clock with `in_stb` high increments `wr_addr` by one, modulo 2^AW. Without `in_stb`, `wr_addr` holds.
- R3: On a clock with `out_stb` high, the design computes step = floor(((M << 20) − ratio) / 2^SHIFT), where M is the measurement of R4. `ratio` becomes ratio + step, and the new value is visible in the next cycle.
- R4: The measurement M counts the cycles with `in_stb` high, from the previous `out_stb` cycle (inclusive) to the current one (exclusive). Before the first output strobe, counting starts at reset. M saturates at 2^AW − 1.
- R5: The position is `{rd_addr, phase}`: the integer part is AW bits, the fraction is 20 bits, and the value wraps modulo 2^AW. On an `out_stb` clock the position gains the old `ratio` plus e·2^(20−ESHIFT). Here e is (wr_addr − OFFSET − rd_addr) read as a signed AW-bit number, using the values before the clock. A carry out of the phase increments `rd_addr`.
- R6: Each `out_stb` clock updates a streak count. The streak saturates at LOCK_N when |step| < LOCK_TH and clears to zero otherwise. `locked` is high exactly when the streak equals LOCK_N, so it changes only in the cycle after an `out_stb` clock.
- R7: Without `out_stb`, `ratio`, `rd_addr`, `phase` and `locked` all hold.
- R8: Suppose the strobes are steady with N input strobes per output strobe. Then `ratio` settles to within LOCK_TH of N << 20, `locked` rises, and `rd_addr` settles within 3 of `wr_addr` − OFFSET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Input sample strobe, one cycle |
| out_stb | input | 1 | Output sample strobe, one cycle |
| wr_addr | output | AW | Buffer write address / input ramp |
| rd_addr | output | AW | Buffer read start address |
| phase | output | FRAC | Fractional position for coefficient selection |
| ratio | output | AW+FRAC | Averaged input/output rate ratio, 20 fractional bits |
| locked | output | 1 | Ratio estimate has settled |

## Verification
Every result of this block appears one clock after the rising edge that samples its strobe:
- `wr_addr` follows `in_stb`.
- `ratio`, `rd_addr`, `phase` and `locked` follow `out_stb`.

The bench drives the strobes just after a falling edge. It waits for the following rising edge, then samples all outputs at the next falling edge. At that point it compares them with a model that it advances by exactly one step for the strobes it drove.

Two directed phases check settling over long runs: steady strobe patterns of 3:1 and then 2:1. A third directed phase is a long stretch without output strobes, which drives the measurement into saturation.

// File: rtl/rate_tracker.sv
module rate_tracker #(
  parameter int AW      = 9,
  parameter int FRAC    = 20,
  parameter int SHIFT   = 4,
  parameter int ESHIFT  = 6,
  parameter int OFFSET  = 16,
  parameter int LOCK_TH = 4096,
  parameter int LOCK_N  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_stb,
  input  logic             out_stb,
  output logic [AW-1:0]    wr_addr,
  output logic [AW-1:0]    rd_addr,
  output logic [FRAC-1:0]  phase,
  output logic [AW+FRAC-1:0] ratio,
  output logic             locked
);
  localparam int PW = AW + FRAC;
  localparam int CS = FRAC - ESHIFT;
  localparam int SW = $clog2(LOCK_N + 1);

  logic [AW-1:0]         icnt;
  logic [PW-1:0]         pos;
  logic [SW-1:0]         streak;
  logic signed [PW+1:0]  diff, stp;
  logic [PW+1:0]         mag;
  logic [AW-1:0]         err;
  logic [PW-1:0]         corr;
  logic                  calm;

  assign diff = $signed({2'b00, icnt, {FRAC{1'b0}}}) - $signed({2'b00, ratio});
  assign stp  = diff >>> SHIFT;
  assign mag  = stp[PW+1] ? $unsigned(-stp) : $unsigned(stp);
  assign calm = mag < (PW+2)'(LOCK_TH);

  assign err  = wr_addr - AW'(OFFSET) - rd_addr;
  assign corr = {{ESHIFT{err[AW-1]}}, err, {CS{1'b0}}};

  assign rd_addr = pos[PW-1:FRAC];
  assign phase   = pos[FRAC-1:0];
  assign locked  = (streak == SW'(LOCK_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      icnt    <= '0;
      ratio   <= PW'(1) << FRAC;
      pos     <= {AW'((1 << AW) - OFFSET), {FRAC{1'b0}}};
      streak  <= '0;
    end else begin
      if (in_stb) wr_addr <= wr_addr + 1'b1;
      if (out_stb) begin
        icnt   <= {{(AW-1){1'b0}}, in_stb};
        ratio  <= ratio + stp[PW-1:0];
        pos    <= pos + ratio + corr;
        streak <= calm ? (locked ? streak : streak + 1'b1) : '0;
      end else if (in_stb && icnt != '1) begin
        icnt <= icnt + 1'b1;
      end
    end
  end
endmodule

module rate_tracker_chk #(
  parameter int AW   = 9,
  parameter int FRAC = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_stb,
  input logic               out_stb,
  input logic [AW-1:0]      wr_addr,
  input logic [AW-1:0]      rd_addr,
  input logic [FRAC-1:0]    phase,
  input logic [AW+FRAC-1:0] ratio,
  input logic               locked
);
  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stb |=> wr_addr == AW'($past(wr_addr) + 1'b1));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |=> $stable(wr_addr));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |=> $stable(ratio) && $stable(rd_addr) && $stable(phase) && $stable(locked));
  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(out_stb));
  // R6
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(out_stb));
endmodule

bind rate_tracker rate_tracker_chk #(.AW(AW), .FRAC(FRAC)) u_chk (.*);

// File: tb/sim_rate_tracker.sv
module sim_rate_tracker;
  logic clk = 0, rst_n = 0, in_stb = 0, out_stb = 0;
  logic [8:0]  wr_addr, rd_addr;
  logic [19:0] phase;
  logic [28:0] ratio;
  logic        locked;

  always #4 clk = ~clk;

  rate_tracker u0 (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  longint m_wr, m_icnt, m_ratio, m_pos, m_streak;
  localparam longint PMASK = (64'd1 << 29) - 1;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint sgn9(longint v);
    longint e = v & 511;
    return (e >= 256) ? e - 512 : e;
  endfunction

  task automatic model_reset();
    m_wr = 0; m_icnt = 0; m_ratio = 64'd1 << 20;
    m_pos = longint'(512 - 16) << 20; m_streak = 0;
  endtask

  task automatic model_step(bit is, bit os);
    longint step, mag, e;
    if (os) begin
      step = ((m_icnt << 20) - m_ratio) >>> 4;
      mag  = (step < 0) ? -step : step;
      e    = sgn9(m_wr - 16 - (m_pos >> 20));
      m_pos = (m_pos + m_ratio + e * 16384) & PMASK;
      m_ratio = (m_ratio + step) & PMASK;
      m_streak = (mag < 4096) ? ((m_streak < 8) ? m_streak + 1 : 8) : 0;
      m_icnt = is;
    end else if (is && m_icnt < 511) m_icnt++;
    if (is) m_wr = (m_wr + 1) % 512;
  endtask

  task automatic compare_all();
    chk("R2 wr_addr", wr_addr, m_wr);
    chk("R3 ratio", ratio, m_ratio);
    chk("R5 rd_addr", rd_addr, m_pos >> 20);
    chk("R5 phase", phase, m_pos & 64'hFFFFF);
    chk("R6 locked", locked, longint'(m_streak == 8));
  endtask

  task automatic cyc(bit is, bit os);
    in_stb = is; out_stb = os;
    @(posedge clk); @(negedge clk);
    model_step(is, os);
    compare_all();
  endtask

  task automatic periodic(int pin, int pout, int n);
    for (int c = 0; c < n; c++) cyc(c % pin == 0, c % pout == pout / 2);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    longint held, d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
    // R1
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 rd_addr", rd_addr, 496);
    chk("R1 phase", phase, 0);
    chk("R1 ratio", ratio, 64'd1 << 20);
    chk("R1 locked", locked, 0);

    // R8: steady 3:1
    periodic(5, 15, 6000);
    chk("R8 locked 3:1", locked, 1);
    d = ratio - (64'd3 << 20); if (d < 0) d = -d;
    chk("R8 ratio near 3.0", longint'(d < 4096), 1);
    d = sgn9(wr_addr - 16 - rd_addr); if (d < 0) d = -d;
    chk("R8 read distance 3:1", longint'(d <= 3), 1);

    // R8: rate change to 2:1, relock
    periodic(7, 14, 6000);
    chk("R8 locked 2:1", locked, 1);
    d = ratio - (64'd2 << 20); if (d < 0) d = -d;
    chk("R8 ratio near 2.0", longint'(d < 4096), 1);
    d = sgn9(wr_addr - 16 - rd_addr); if (d < 0) d = -d;
    chk("R8 read distance 2:1", longint'(d <= 3), 1);

    // R7: many input strobes, no output strobe
    held = ratio;
    for (int i = 0; i < 600; i++) cyc(1, 0);
    chk("R7 ratio held", ratio, held);
    // R4: saturated measurement feeds step
    cyc(0, 1);
    chk("R4 saturated update", ratio,
        (held + (((longint'(511) << 20) - held) >>> 4)) & PMASK);
    chk("R6 lock lost", locked, 0);

    // random strobes
    for (int i = 0; i < 8000; i++) cyc($urandom_range(2) == 0, $urandom_range(4) == 0);
    // coincident strobes
    for (int i = 0; i < 200; i++) cyc(1, i % 3 == 0);

    done = 1;
    summary();
    $finish;
  end
endmodule